// File: doc/BRIEF.md
# EPP Host Port Controller

This block is the host side of an enhanced parallel port. A processor reaches five byte-wide registers at a parameterised base address through a simple request/ready register bus. Three of them (data, status, control) act as plain registers, with the status and control bits flipped where the port hardware inverts them. The other two start a full strobe-and-wait handshake on the external port, one using the address strobe and one using the data strobe.

During a handshake the bus is stalled until the peripheral has answered, so software sees one register access per port cycle. The peripheral's wait line passes through a two-flop synchronizer. A cycle counter ends a cycle whose peripheral never answers and records the event in the status register. Control bit 2 drives an active-low reset to the peripheral. While that reset is held, the handshake logic stays idle.

Top module: `epp_host_port`

## Requirements
- R1: Registers sit at BASE+0 (data), BASE+1 (status), BASE+2 (control), BASE+3 (EPP address) and BASE+4 (EPP data), with BASE = 0x378 by default. Any other address reads 0x00 and a write to it changes nothing.
- R2: A write to offset 0 places the byte on `pd_out` with `pd_oe` high while no port cycle runs. A read of offset 0 returns `pd_in` without inversion. After reset `pd_out` is 0x00.
- R3: A read of offset 1 returns bit 7 = inverted `sts_pins[4]`, bits 6..3 = `sts_pins[3:0]`, bits 2..1 = 0 and bit 0 = the timeout flag.
- R4: The control register resets to 0x04 and reads back as written. `ctl_pins[3:0]` equals control bits 3..0 XOR 4'b1011.
- R5: An access to offset 3 or 4 with write set drives `nwrite` low and the byte on `pd_out` with `pd_oe` high. Offset 3 pulls only `naddr_stb` low and offset 4 pulls only `ndata_stb` low.
- R6: An EPP read keeps `nwrite` high and `pd_oe` low while the strobe is low. It returns the `pd_in` byte captured while wait was seen high.
- R7: The strobe goes low from idle. It is released only after wait is seen high. `bus_ready` comes only after wait has fallen again, never while a strobe is low. The two strobes are never low together.
- R8: A wait rise reaches the handshake only through two flops, so a strobe is released no sooner than three clock edges after `wait_in` was sampled high.
- R9: If a cycle has not completed TO_CYC = CLK_MHZ*TIMEOUT_US clocks (2500 by default) after it starts, the strobe is released and the access completes. A read then returns 0xFF and the status timeout flag (bit 0) is set. Any write to offset 1 clears the flag.
- R10: `host_rst_n` follows control bit 2. While it is low, an access to offset 3 or 4 completes in one cycle with no strobe and reads 0x00.
- R11: `bus_ready` is a one-cycle pulse. It follows a request to offsets 0–2 or to an unmapped address one cycle later, and for an EPP access it follows cycle completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, held until `bus_ready` |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid with `bus_ready` |
| bus_ready | output | 1 | Access complete pulse |
| pd_in | input | 8 | Port data pins, input side |
| pd_out | output | 8 | Port data pins, output side |
| pd_oe | output | 1 | Port data output enable |
| sts_pins | input | 5 | Status pins, bits 7..3 |
| ctl_pins | output | 4 | Control pins, bits 3..0 |
| host_rst_n | output | 1 | Active-low reset to the peripheral |
| nwrite | output | 1 | Direction line, low for host writes |
| naddr_stb | output | 1 | Address strobe, active low |
| ndata_stb | output | 1 | Data strobe, active low |
| wait_in | input | 1 | Peripheral wait handshake |

## Verification
On every cycle the assertions check the following: the two strobes are never low together, the bus direction matches the cycle type, no ready appears while a strobe is low, ready lasts one cycle, a strobe release needs wait seen three edges earlier, a timeout sets the flag, and a held host reset keeps both strobes high. Only the bench scenarios can show the register decode and bit inversions, the bytes moved in each cycle type, the read value after a timeout, the clearing of the flag, and the access latencies. It does this by comparing queued expected values with the returned data and with what a peripheral model observes.

// File: rtl/epp_host_pkg.sv
package epp_host_pkg;

  typedef enum logic [2:0] {
    P_DATA, P_STAT, P_CTRL, P_EADR, P_EDAT, P_NONE
  } port_e;

  typedef enum logic [1:0] {C_IDLE, C_STRB, C_REL} cyc_e;

  typedef enum logic [1:0] {B_IDLE, B_EPP, B_ACK} bus_e;

  localparam logic [7:0] STS_INV = 8'h80;
  localparam logic [7:0] CTL_INV = 8'h0B;
  localparam int unsigned NPORTS = 5;

  function automatic port_e decode_port(input logic [31:0] addr, input logic [31:0] base);
    logic [31:0] off;
    off = addr - base;
    if (addr < base || off >= NPORTS) return P_NONE;
    case (off[2:0])
      3'd0: return P_DATA;
      3'd1: return P_STAT;
      3'd2: return P_CTRL;
      3'd3: return P_EADR;
      default: return P_EDAT;
    endcase
  endfunction

  function automatic logic [7:0] status_view(input logic [4:0] pins, input logic flag);
    return ({pins, 3'b000} ^ STS_INV) | {7'b0, flag};
  endfunction

  function automatic logic [3:0] ctrl_to_pins(input logic [7:0] ctrl);
    logic [7:0] v;
    v = ctrl ^ CTL_INV;
    return v[3:0];
  endfunction

endpackage

// File: rtl/epp_sync2.sv
module epp_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
  import epp_host_pkg::*;
#(
  parameter int TO_CYC = 2500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic       start,
  input  logic       is_addr,
  input  logic       is_rd,
  input  logic [7:0] wbyte,
  input  logic       wait_s,
  input  logic [7:0] pd_in,
  output logic       busy,
  output logic       drive,
  output logic [7:0] drive_byte,
  output logic       naddr_stb,
  output logic       ndata_stb,
  output logic       nwrite,
  output logic       done,
  output logic       tmo,
  output logic [7:0] rbyte
);
  localparam int CW = $clog2(TO_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(TO_CYC - 1);

  cyc_e       state;
  logic       addr_q, rd_q;
  logic [7:0] wq, cap;
  logic [CW-1:0] cnt;
  logic       nat_done;

  assign busy       = (state != C_IDLE);
  assign nat_done   = (state == C_REL) && !wait_s;
  assign tmo        = busy && (cnt == LIM) && !nat_done;
  assign done       = nat_done || tmo;
  assign drive      = busy && !rd_q;
  assign drive_byte = wq;
  assign naddr_stb  = !((state == C_STRB) && addr_q);
  assign ndata_stb  = !((state == C_STRB) && !addr_q);
  assign nwrite     = !(busy && !rd_q);
  assign rbyte      = tmo ? 8'hFF : cap;

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      state  <= C_IDLE;
      addr_q <= 1'b0;
      rd_q   <= 1'b0;
      wq     <= 8'h00;
      cap    <= 8'h00;
      cnt    <= '0;
    end else if (tmo) begin
      state <= C_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        C_IDLE: if (start) begin
          state  <= C_STRB;
          addr_q <= is_addr;
          rd_q   <= is_rd;
          wq     <= wbyte;
          cnt    <= '0;
        end
        C_STRB: begin
          cnt <= cnt + 1'b1;
          if (wait_s) begin
            cap   <= pd_in;
            state <= C_REL;
          end
        end
        C_REL: begin
          cnt <= cnt + 1'b1;
          if (!wait_s) state <= C_IDLE;
        end
        default: state <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/epp_host_port.sv
module epp_host_port
  import epp_host_pkg::*;
#(
  parameter int          AW         = 16,
  parameter logic [31:0] BASE       = 32'h378,
  parameter int          CLK_MHZ    = 250,
  parameter int          TIMEOUT_US = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          bus_ready,
  input  logic [7:0]    pd_in,
  output logic [7:0]    pd_out,
  output logic          pd_oe,
  input  logic [4:0]    sts_pins,
  output logic [3:0]    ctl_pins,
  output logic          host_rst_n,
  output logic          nwrite,
  output logic          naddr_stb,
  output logic          ndata_stb,
  input  logic          wait_in
);
  localparam int TO_CYC = CLK_MHZ * TIMEOUT_US;

  bus_e       bstate;
  logic [7:0] data_reg, ctrl_reg;
  logic       tmo_flag;
  logic       rd_q;
  port_e      sel;
  logic       is_epp, hold, start;
  logic       wait_s;
  logic       cyc_busy, cyc_drive, cyc_done, cyc_timeout;
  logic [7:0] cyc_byte, cyc_rbyte;

  assign sel    = decode_port({{(32-AW){1'b0}}, bus_addr}, BASE);
  assign is_epp = (sel == P_EADR) || (sel == P_EDAT);
  assign hold   = !ctrl_reg[2];
  assign start  = (bstate == B_IDLE) && bus_req && is_epp && !hold;

  assign bus_ready  = (bstate == B_ACK);
  assign host_rst_n = ctrl_reg[2];
  assign ctl_pins   = ctrl_to_pins(ctrl_reg);
  assign pd_oe      = cyc_busy ? cyc_drive : 1'b1;
  assign pd_out     = cyc_drive ? cyc_byte : data_reg;

  epp_sync2 #(.W(1)) u_wsync (
    .clk(clk), .rst_n(rst_n), .d(wait_in), .q(wait_s)
  );

  epp_cycle_fsm #(.TO_CYC(TO_CYC)) u_cyc (
    .clk(clk), .rst_n(rst_n), .hold(hold), .start(start),
    .is_addr(sel == P_EADR), .is_rd(!bus_wr), .wbyte(bus_wdata),
    .wait_s(wait_s), .pd_in(pd_in),
    .busy(cyc_busy), .drive(cyc_drive), .drive_byte(cyc_byte),
    .naddr_stb(naddr_stb), .ndata_stb(ndata_stb), .nwrite(nwrite),
    .done(cyc_done), .tmo(cyc_timeout), .rbyte(cyc_rbyte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bstate    <= B_IDLE;
      data_reg  <= 8'h00;
      ctrl_reg  <= 8'h04;
      tmo_flag  <= 1'b0;
      bus_rdata <= 8'h00;
      rd_q      <= 1'b0;
    end else begin
      case (bstate)
        B_IDLE: if (bus_req) begin
          rd_q   <= !bus_wr;
          bstate <= B_ACK;
          case (sel)
            P_DATA: begin
              if (bus_wr) data_reg <= bus_wdata;
              bus_rdata <= pd_in;
            end
            P_STAT: begin
              if (bus_wr) tmo_flag <= 1'b0;
              bus_rdata <= status_view(sts_pins, tmo_flag);
            end
            P_CTRL: begin
              if (bus_wr) ctrl_reg <= bus_wdata;
              bus_rdata <= bus_wr ? bus_wdata : ctrl_reg;
            end
            P_EADR, P_EDAT: begin
              bus_rdata <= 8'h00;
              if (!hold) bstate <= B_EPP;
            end
            default: bus_rdata <= 8'h00;
          endcase
        end
        B_EPP: if (cyc_done) begin
          bus_rdata <= rd_q ? cyc_rbyte : 8'h00;
          if (cyc_timeout) tmo_flag <= 1'b1;
          bstate <= B_ACK;
        end
        default: bstate <= B_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/epp_host_port_chk.sv
module epp_host_port_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_ready,
  input logic pd_oe,
  input logic nwrite,
  input logic naddr_stb,
  input logic ndata_stb,
  input logic wait_in,
  input logic host_rst_n,
  input logic cyc_timeout,
  input logic tmo_flag
);
  logic strb_low;
  assign strb_low = !naddr_stb || !ndata_stb;

  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!naddr_stb && !ndata_stb));

  a_r7_no_ready_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> !strb_low);

  a_r6_read_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_low && nwrite) |-> !pd_oe);

  a_r5_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_low && !nwrite) |-> pd_oe);

  a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(naddr_stb && ndata_stb) && !$past(cyc_timeout)) |-> $past(wait_in, 3));

  a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);

  a_r9_timeout_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_timeout |=> tmo_flag);

  a_r10_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rst_n |-> (naddr_stb && ndata_stb));
endmodule

bind epp_host_port epp_host_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_ready(bus_ready), .pd_oe(pd_oe),
  .nwrite(nwrite), .naddr_stb(naddr_stb), .ndata_stb(ndata_stb),
  .wait_in(wait_in), .host_rst_n(host_rst_n),
  .cyc_timeout(cyc_timeout), .tmo_flag(tmo_flag)
);

// File: tb/epp_host_port_test.sv
module epp_host_port_test;
  localparam int AW = 16;
  localparam logic [15:0] B = 16'h0378;
  localparam int TO = 2500;

  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic bus_ready;
  logic [7:0] pin_byte = 8'h00;
  wire  [7:0] pd_in = pin_byte;
  logic [7:0] pd_out;
  logic pd_oe;
  logic [4:0] sts_pins = 5'b0;
  logic [3:0] ctl_pins;
  logic host_rst_n, nwrite, naddr_stb, ndata_stb;
  logic wait_in = 0;

  int total = 0, bad = 0, periph_cnt = 0;
  logic periph_dead = 0;

  typedef struct { logic chk; logic [7:0] val; logic epp; logic tmo; string tag; } item_t;
  typedef struct { logic is_addr; logic wr; logic [7:0] val; } pev_t;
  item_t exp_q[$];
  pev_t  pexp_q[$];

  always #2 clk = ~clk;

  epp_host_port uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
    .sts_pins(sts_pins), .ctl_pins(ctl_pins), .host_rst_n(host_rst_n),
    .nwrite(nwrite), .naddr_stb(naddr_stb), .ndata_stb(ndata_stb),
    .wait_in(wait_in)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (bus_ready) begin
      if (exp_q.size() == 0) check(0, "R11 unexpected ready", 1, 0);
      else begin
        item_t it;
        it = exp_q.pop_front();
        if (it.chk) check(bus_rdata == it.val, it.tag, bus_rdata, it.val);
        if (it.epp && !it.tmo) check(wait_in == 0, "R7 ready after wait fell", wait_in, 0);
      end
    end
  end

  // peripheral model
  initial forever begin
    @(negedge clk);
    if (!periph_dead && (!naddr_stb || !ndata_stb)) begin
      pev_t ev;
      int held;
      ev.is_addr = !naddr_stb;
      ev.wr = !nwrite;
      if (ev.wr) begin
        check(pd_oe == 1, "R5 bus driven on write", pd_oe, 1);
        ev.val = pd_out;
      end else begin
        check(pd_oe == 0, "R6 bus released on read", pd_oe, 0);
        ev.val = pin_byte;
      end
      periph_cnt++;
      repeat (3) @(negedge clk);
      wait_in = 1;
      held = 0;
      while (!naddr_stb || !ndata_stb) begin @(negedge clk); held++; end
      check(held >= 2, "R8 strobe held through sync", held, 2);
      repeat (2) @(negedge clk);
      wait_in = 0;
      if (pexp_q.size() == 0) check(0, "R5 unexpected port cycle", 1, 0);
      else begin
        pev_t e;
        e = pexp_q.pop_front();
        check(ev.is_addr == e.is_addr && ev.wr == e.wr && ev.val == e.val,
              ev.is_addr ? "R5 address strobe cycle" : "R6 data strobe cycle",
              {ev.is_addr, ev.wr, ev.val}, {e.is_addr, e.wr, e.val});
      end
    end
  end

  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [7:0] wd,
                        input logic chk, input logic [7:0] ev, input logic epp,
                        input logic tmo, input string tag, output int lat);
    item_t it;
    it.chk = chk; it.val = ev; it.epp = epp; it.tmo = tmo; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    bus_req = 1; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!bus_ready && lat < 5000);
    bus_req = 0;
  endtask

  task automatic pexp(input logic is_addr, input logic wr, input logic [7:0] v);
    pev_t e;
    e.is_addr = is_addr; e.wr = wr; e.val = v;
    pexp_q.push_back(e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat, pc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!bus_ready && naddr_stb && ndata_stb && nwrite, "R11 reset idle", {bus_ready, naddr_stb, ndata_stb, nwrite}, 4'b0111);
    check(pd_oe && pd_out == 8'h00, "R2 reset data port", pd_out, 0);
    check(ctl_pins == 4'b1111 && host_rst_n, "R4 reset control pins", ctl_pins, 4'hF);

    access(0, B + 2, 0, 1, 8'h04, 0, 0, "R4 control reset value", lat);
    check(lat == 1, "R11 register latency", lat, 1);
    access(1, B + 2, 8'h05, 0, 0, 0, 0, "R4 control write", lat);
    @(negedge clk);
    check(ctl_pins == 4'b1110, "R4 control pin inversion", ctl_pins, 4'hE);
    access(0, B + 2, 0, 1, 8'h05, 0, 0, "R4 control readback", lat);

    access(1, B + 0, 8'hA5, 0, 0, 0, 0, "R2 data write", lat);
    @(negedge clk);
    check(pd_out == 8'hA5 && pd_oe, "R2 data pins", pd_out, 8'hA5);
    pin_byte = 8'h3C;
    access(0, B + 0, 0, 1, 8'h3C, 0, 0, "R2 data pin read", lat);

    sts_pins = 5'b10110;
    access(0, B + 1, 0, 1, 8'h30, 0, 0, "R3 status view a", lat);
    sts_pins = 5'b01001;
    access(0, B + 1, 0, 1, 8'hC8, 0, 0, "R3 status view b", lat);

    access(0, B + 5, 0, 1, 8'h00, 0, 0, "R1 unmapped above", lat);
    check(lat == 1, "R11 unmapped latency", lat, 1);
    access(0, B - 1, 0, 1, 8'h00, 0, 0, "R1 unmapped below", lat);
    access(1, B + 7, 8'hFF, 0, 0, 0, 0, "R1 unmapped write", lat);
    @(negedge clk);
    check(pd_out == 8'hA5 && ctl_pins == 4'b1110, "R1 unmapped write no effect", pd_out, 8'hA5);

    pexp(1, 1, 8'h5A);
    access(1, B + 3, 8'h5A, 0, 0, 1, 0, "R5 address write", lat);
    check(lat > 6, "R7 EPP access stalls", lat, 7);
    pexp(0, 1, 8'hC3);
    access(1, B + 4, 8'hC3, 0, 0, 1, 0, "R5 data write", lat);
    pin_byte = 8'h96;
    pexp(0, 0, 8'h96);
    access(0, B + 4, 0, 1, 8'h96, 1, 0, "R6 data read", lat);
    pin_byte = 8'h21;
    pexp(1, 0, 8'h21);
    access(0, B + 3, 0, 1, 8'h21, 1, 0, "R6 address read", lat);
    @(negedge clk);
    check(pd_oe && pd_out == 8'hA5, "R2 data port restored", pd_out, 8'hA5);

    periph_dead = 1;
    sts_pins = 5'b10110;
    access(0, B + 4, 0, 1, 8'hFF, 1, 1, "R9 timeout read value", lat);
    check(lat >= TO && lat <= TO + 4, "R9 timeout latency", lat, TO);
    check(naddr_stb && ndata_stb, "R9 strobe released", ndata_stb, 1);
    periph_dead = 0;
    access(0, B + 1, 0, 1, 8'h31, 0, 0, "R9 timeout flag set", lat);
    access(1, B + 1, 8'h00, 0, 0, 0, 0, "R9 flag clear", lat);
    access(0, B + 1, 0, 1, 8'h30, 0, 0, "R9 timeout flag cleared", lat);

    access(1, B + 2, 8'h01, 0, 0, 0, 0, "R10 host reset on", lat);
    @(negedge clk);
    check(host_rst_n == 0, "R10 host reset pin", host_rst_n, 0);
    pc = periph_cnt;
    pin_byte = 8'h77;
    access(0, B + 4, 0, 1, 8'h00, 0, 0, "R10 read under reset", lat);
    check(lat == 1, "R10 immediate completion", lat, 1);
    check(periph_cnt == pc, "R10 no strobe under reset", periph_cnt, pc);
    access(1, B + 2, 8'h04, 0, 0, 0, 0, "R10 host reset off", lat);

    pexp(0, 1, 8'h0F);
    access(1, B + 4, 8'h0F, 0, 0, 1, 0, "R7 cycle after timeout", lat);
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0 && pexp_q.size() == 0, "R7 all items seen", exp_q.size() + pexp_q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule